// File: doc/BRIEF.md
# Single-Data-Rate SDRAM Command Sequencer

This block sits between a simple host port and a four-bank, byte-wide single-data-rate SDRAM. After reset it brings the memory up: a stabilisation wait, a precharge of every bank, two refresh cycles and a mode register load. It then serves one host transfer at a time. Each transfer opens a row, performs one column access, and closes the bank again, so no row stays open between transfers.

All command spacing is derived when the design is elaborated. Nanosecond limits are divided by the clock period and rounded up to whole cycles. A free-running interval timer raises a refresh request. The request is served at the next idle slot, ahead of any waiting host transfer, so the memory gets its 4096 refreshes within every 64 ms. Read data is taken from the data bus a fixed number of cycles after the read command, set by the programmed CAS latency, and is handed back with a one-cycle valid strobe.

Top module: `sdrc_ctrl`

## Requirements
- R1: During reset CKE is low, chip select is high (deselect), DQM is high, and host_ack and host_rvalid are low. DQM stays high through the mode register load and is low for every column access.
- R2: After at least POWERUP_CYC cycles, the first four commands, in order, are: PRECHARGE with A10 high, AUTO REFRESH, AUTO REFRESH, MODE REGISTER SET. The commands are coded on {cs_n,ras_n,cas_n,we_n} as PRECHARGE=0010, AUTO REFRESH=0001, MODE REGISTER SET=0000, ACTIVE=0011, READ=0101, WRITE=0100, NOP=0111. The MODE REGISTER SET carries BA=0 and A=0x230. In that value A2..A0=000 selects burst length 1, A3=0 selects sequential bursts, A6..A4 hold the CAS latency (3), and A9=1 selects single-location writes.
- R3: The host address splits as bank = host_addr[22:21], row = host_addr[20:9] and column = host_addr[8:0].
- R4: No host request is acknowledged until at least 2 cycles after the mode register load.
- R5: ACTIVE carries the request's bank on BA and its row on A. The following READ or WRITE carries the same bank, the column on A[8:0], and A9, A10 and A11 low.
- R6: READ or WRITE follows its ACTIVE after exactly tRCD (3) cycles. The closing PRECHARGE has A10 low, addresses the same bank, and comes no sooner than tRAS (6) cycles after the ACTIVE.
- R7: An ACTIVE or AUTO REFRESH comes at least tRP (3) cycles after a PRECHARGE. Two ACTIVE commands are at least tRC (9) cycles apart.
- R8: The data-bus output enable is high only in the WRITE cycle, and sd_dq_out then carries the request's write byte.
- R9: For a READ, the data bus is sampled at the CAS-latency-th rising edge after the edge on which the memory takes the READ. host_rvalid is high for one cycle, CAS latency + 1 cycles after the READ appears on the pins, with that byte on host_rdata.
- R10: After initialisation, consecutive AUTO REFRESH commands are at most REF_INTERVAL + 16 cycles apart, even under back-to-back host requests.
- R11: host_ack is a single-cycle pulse, given once for each accepted request.
- R12: No command follows an AUTO REFRESH within tRFC (9) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Transfer request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 23 | Linear address {bank,row,column} |
| host_wdata | input | 8 | Write byte |
| host_ack | output | 1 | One-cycle acceptance pulse |
| host_rdata | output | 8 | Read byte |
| host_rvalid | output | 1 | One-cycle strobe qualifying host_rdata |
| sd_cke | output | 1 | Memory clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 1 | Data mask |
| sd_dq_out | output | 8 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 8 | Data returned by the memory |

## Verification
The hardest case to reach is a refresh request that becomes due while host requests keep arriving. The refresh must then win the idle slot and still land within the interval bound. The timer runs freely from reset and cannot be aimed at from the ports. The stimulus therefore issues several hundred back-to-back write and read transfers with no gap, spanning several refresh periods. Each refresh deadline is then certain to fall while a request is pending. A behavioural memory model stores the written bytes and returns them after the CAS latency, and a scoreboard compares every returned byte.

// File: rtl/sdrc_pkg.sv
`timescale 1ns/1ps
package sdrc_pkg;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 9;
    localparam int DQ_W   = 8;
    localparam int ADDR_W = BANK_W + ROW_W + COL_W;

    localparam int T_RCD_NS  = 20;
    localparam int T_RP_NS   = 20;
    localparam int T_RAS_NS  = 45;
    localparam int T_RC_NS   = 65;
    localparam int T_RFC_NS  = 65;
    localparam int T_MRD_CYC = 2;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WR    = 4'b0100,
        CMD_RD    = 4'b0101,
        CMD_BST   = 4'b0110,
        CMD_NOP   = 4'b0111,
        CMD_DESEL = 4'b1111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR, ST_INIT_PRE, ST_INIT_REF1, ST_INIT_REF2, ST_INIT_MRS,
        ST_IDLE, ST_ACT, ST_RW, ST_PRE, ST_REF, ST_WAIT
    } seq_st_e;

    typedef struct packed {
        logic              we;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DQ_W-1:0]   wdata;
    } host_xfer_t;

    typedef struct packed {
        sd_cmd_e           cmd;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic              oe;
        logic [DQ_W-1:0]   dout;
    } pin_bus_t;

    function automatic int ns_to_cyc(input int ns, input int period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    function automatic int max2(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic logic [ROW_W-1:0] mode_word(input int cas_lat);
        logic [ROW_W-1:0] m;
        m      = '0;
        m[2:0] = 3'b000;          // one beat per access
        m[3]   = 1'b0;            // sequential ordering
        m[6:4] = 3'(cas_lat);     // read latency
        m[9]   = 1'b1;            // writes touch one location
        return m;
    endfunction
endpackage

// File: rtl/sdrc_wait_cnt.sv
`timescale 1ns/1ps
module sdrc_wait_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= W'(RST_VAL);
        else if (load)         cnt <= load_val;
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign done = (cnt <= W'(1));
endmodule

// File: rtl/sdrc_ref_timer.sv
`timescale 1ns/1ps
module sdrc_ref_timer #(
    parameter int INTERVAL = 2048
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic pend
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)     pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/sdrc_rd_capture.sv
`timescale 1ns/1ps
module sdrc_rd_capture #(
    parameter int CL = 3,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_on_bus,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);
    logic [CL-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '0;
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            pipe   <= {pipe[CL-2:0], rd_on_bus};
            rvalid <= pipe[CL-1];
            if (pipe[CL-1]) rdata <= dq_in;
        end
    end
endmodule

// File: rtl/sdrc_ctrl.sv
`timescale 1ns/1ps
module sdrc_ctrl
    import sdrc_pkg::*;
#(
    parameter int CLK_PS       = 7500,
    parameter int POWERUP_CYC  = 26667,
    parameter int REF_INTERVAL = 2048,
    parameter int CAS_LAT      = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 host_req,
    input  logic                 host_we,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DQ_W-1:0]      host_wdata,
    output logic                 host_ack,
    output logic [DQ_W-1:0]      host_rdata,
    output logic                 host_rvalid,
    output logic                 sd_cke,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BANK_W-1:0]    sd_ba,
    output logic [ROW_W-1:0]     sd_a,
    output logic                 sd_dqm,
    output logic [DQ_W-1:0]      sd_dq_out,
    output logic                 sd_dq_oe,
    input  logic [DQ_W-1:0]      sd_dq_in
);
    localparam int TRCD     = ns_to_cyc(T_RCD_NS, CLK_PS);
    localparam int TRP      = ns_to_cyc(T_RP_NS,  CLK_PS);
    localparam int TRAS     = ns_to_cyc(T_RAS_NS, CLK_PS);
    localparam int TRC      = ns_to_cyc(T_RC_NS,  CLK_PS);
    localparam int TRFC     = ns_to_cyc(T_RFC_NS, CLK_PS);
    localparam int T_RW_PRE = max2(max2(TRAS - TRCD, TRC - TRCD - TRP - 1), 2);
    localparam int T_MAX    = max2(max2(POWERUP_CYC, TRFC), max2(T_RW_PRE, TRP));
    localparam int CNT_W    = $clog2(T_MAX + 1);

    seq_st_e          st, st_nx, ret, ret_nx;
    host_xfer_t       cur;
    pin_bus_t         pins, nx;
    logic             ld, w_done, accept, ref_pend, ref_clr, init_done;
    logic [CNT_W-1:0] ld_val;

    sdrc_wait_cnt #(.W(CNT_W), .RST_VAL(POWERUP_CYC)) u_wait (
        .clk(clk), .rst(rst), .load(ld), .load_val(ld_val), .done(w_done)
    );

    sdrc_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .clr(ref_clr), .pend(ref_pend)
    );

    sdrc_rd_capture #(.CL(CAS_LAT), .DW(DQ_W)) u_rd (
        .clk(clk), .rst(rst), .rd_on_bus(pins.cmd == CMD_RD),
        .dq_in(sd_dq_in), .rdata(host_rdata), .rvalid(host_rvalid)
    );

    always_comb begin
        nx      = '{cmd: CMD_NOP, ba: '0, a: '0, oe: 1'b0, dout: cur.wdata};
        st_nx   = st;
        ret_nx  = ret;
        ld      = 1'b0;
        ld_val  = '0;
        accept  = 1'b0;
        ref_clr = 1'b0;
        case (st)
            ST_PWR: if (w_done) st_nx = ST_INIT_PRE;
            ST_INIT_PRE: begin
                nx.cmd = CMD_PRE; nx.a[10] = 1'b1;
                ld = 1'b1; ld_val = CNT_W'(TRP - 1);
                ret_nx = ST_INIT_REF1; st_nx = ST_WAIT;
            end
            ST_INIT_REF1: begin
                nx.cmd = CMD_REF;
                ld = 1'b1; ld_val = CNT_W'(TRFC - 1);
                ret_nx = ST_INIT_REF2; st_nx = ST_WAIT;
            end
            ST_INIT_REF2: begin
                nx.cmd = CMD_REF;
                ld = 1'b1; ld_val = CNT_W'(TRFC - 1);
                ret_nx = ST_INIT_MRS; st_nx = ST_WAIT;
            end
            ST_INIT_MRS: begin
                nx.cmd = CMD_MRS; nx.a = mode_word(CAS_LAT);
                ld = 1'b1; ld_val = CNT_W'(T_MRD_CYC - 1);
                ret_nx = ST_IDLE; st_nx = ST_WAIT;
            end
            ST_IDLE: begin
                if (ref_pend)      st_nx = ST_REF;
                else if (host_req) begin accept = 1'b1; st_nx = ST_ACT; end
            end
            ST_ACT: begin
                nx.cmd = CMD_ACT; nx.ba = cur.bank; nx.a = cur.row;
                ld = 1'b1; ld_val = CNT_W'(TRCD - 1);
                ret_nx = ST_RW; st_nx = ST_WAIT;
            end
            ST_RW: begin
                nx.cmd = cur.we ? CMD_WR : CMD_RD;
                nx.ba = cur.bank; nx.a[COL_W-1:0] = cur.col; nx.oe = cur.we;
                ld = 1'b1; ld_val = CNT_W'(T_RW_PRE - 1);
                ret_nx = ST_PRE; st_nx = ST_WAIT;
            end
            ST_PRE: begin
                nx.cmd = CMD_PRE; nx.ba = cur.bank;
                ld = 1'b1; ld_val = CNT_W'(TRP - 1);
                ret_nx = ST_IDLE; st_nx = ST_WAIT;
            end
            ST_REF: begin
                nx.cmd = CMD_REF; ref_clr = 1'b1;
                ld = 1'b1; ld_val = CNT_W'(TRFC - 1);
                ret_nx = ST_IDLE; st_nx = ST_WAIT;
            end
            ST_WAIT: if (w_done) st_nx = ret;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PWR;
            ret       <= ST_IDLE;
            cur       <= '0;
            pins      <= '{cmd: CMD_DESEL, ba: '0, a: '0, oe: 1'b0, dout: '0};
            sd_cke    <= 1'b0;
            sd_dqm    <= 1'b1;
            host_ack  <= 1'b0;
            init_done <= 1'b0;
        end else begin
            st       <= st_nx;
            ret      <= ret_nx;
            pins     <= nx;
            sd_cke   <= 1'b1;
            host_ack <= accept;
            sd_dqm   <= ~init_done;
            if (st == ST_INIT_MRS) init_done <= 1'b1;
            if (accept) begin
                cur.we    <= host_we;
                cur.bank  <= host_addr[ADDR_W-1 -: BANK_W];
                cur.row   <= host_addr[COL_W +: ROW_W];
                cur.col   <= host_addr[COL_W-1:0];
                cur.wdata <= host_wdata;
            end
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pins.cmd;
    assign sd_ba     = pins.ba;
    assign sd_a      = pins.a;
    assign sd_dq_oe  = pins.oe;
    assign sd_dq_out = pins.dout;
endmodule

// File: rtl/sdrc_ctrl_chk.sv
`timescale 1ns/1ps
module sdrc_ctrl_chk
    import sdrc_pkg::*;
#(
    parameter int CLK_PS       = 7500,
    parameter int REF_INTERVAL = 2048
) (
    input logic              clk,
    input logic              rst,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic              sd_dq_oe,
    input logic              host_ack
);
    localparam int TRCD = ns_to_cyc(T_RCD_NS, CLK_PS);
    localparam int TRP  = ns_to_cyc(T_RP_NS,  CLK_PS);
    localparam int TRAS = ns_to_cyc(T_RAS_NS, CLK_PS);
    localparam int TRC  = ns_to_cyc(T_RC_NS,  CLK_PS);
    localparam int TRFC = ns_to_cyc(T_RFC_NS, CLK_PS);

    logic [3:0]  cmd;
    logic [31:0] since_act, since_pre, since_ref;
    logic        act_seen, pre_seen, ref_seen;
    logic        is_cmd;

    assign cmd    = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_cmd = !sd_cs_n && (cmd != CMD_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0; since_pre <= '0; since_ref <= '0;
            act_seen  <= 1'b0; pre_seen <= 1'b0; ref_seen <= 1'b0;
        end else begin
            since_act <= (cmd == CMD_ACT) ? 32'd1 : since_act + 32'd1;
            since_pre <= (cmd == CMD_PRE) ? 32'd1 : since_pre + 32'd1;
            since_ref <= (cmd == CMD_REF) ? 32'd1 : since_ref + 32'd1;
            if (cmd == CMD_ACT) act_seen <= 1'b1;
            if (cmd == CMD_PRE) pre_seen <= 1'b1;
            if (cmd == CMD_REF) ref_seen <= 1'b1;
        end
    end

    assert_rcd_exact_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (act_seen && since_act == 32'(TRCD)));

    assert_ras_min_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && act_seen) |-> since_act >= 32'(TRAS));

    assert_rp_min_R7: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_ACT || cmd == CMD_REF) && pre_seen) |-> since_pre >= 32'(TRP));

    assert_rc_min_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT && act_seen) |-> since_act >= 32'(TRC));

    assert_oe_write_only_R8: assert property (@(posedge clk) disable iff (rst)
        sd_dq_oe |-> (cmd == CMD_WR));

    assert_ref_interval_R10: assert property (@(posedge clk) disable iff (rst)
        ref_seen |-> since_ref < 32'(REF_INTERVAL + 16));

    assert_ack_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        host_ack |=> !host_ack);

    assert_rfc_min_R12: assert property (@(posedge clk) disable iff (rst)
        (is_cmd && ref_seen) |-> since_ref >= 32'(TRFC));
endmodule

bind sdrc_ctrl sdrc_ctrl_chk #(.CLK_PS(CLK_PS), .REF_INTERVAL(REF_INTERVAL)) u_chk (
    .clk(clk), .rst(rst), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dq_oe(sd_dq_oe),
    .host_ack(host_ack)
);

// File: tb/sdrc_ctrl_tb.sv
`timescale 1ns/1ps
module sdrc_ctrl_tb;
    localparam int PWR  = 50;
    localparam int REFI = 2048;
    localparam int CL   = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [22:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ack, host_rvalid;
    logic [7:0]  host_rdata;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, sd_dq_oe;
    logic [1:0]  sd_ba;
    logic [11:0] sd_a;
    logic [7:0]  sd_dq_out;
    logic [7:0]  sd_dq_in = '0;

    always #5 clk = ~clk;

    sdrc_ctrl #(.POWERUP_CYC(PWR), .REF_INTERVAL(REFI), .CAS_LAT(CL)) u_dut (
        .clk(clk), .rst(rst), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rdata(host_rdata), .host_rvalid(host_rvalid), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm),
        .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at %0t",
                     req, act, act, exp, exp, $time);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- memory model ----------------
    logic [11:0] open_row [4];
    logic [7:0]  mem [int];
    logic [7:0]  mp0 = '0, mp1 = '0;
    logic [3:0]  mcmd;
    int          mkey;

    always @(posedge clk) begin
        mcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        mkey = int'({sd_ba, open_row[sd_ba], sd_a[8:0]});
        mp1      <= mp0;
        sd_dq_in <= mp1;
        if (mcmd == 4'b0011) open_row[sd_ba] = sd_a;
        if (mcmd == 4'b0100 && sd_dq_oe) mem[mkey] = sd_dq_out;
        if (mcmd == 4'b0101) mp0 <= mem.exists(mkey) ? mem[mkey] : 8'h00;
    end

    // ---------------- scoreboard state ----------------
    logic [7:0] exp_mem [int];
    logic [7:0] sb_q [$];
    int         addr_q [$];
    bit         we_q [$];
    logic [7:0] dat_q [$];
    int         rd_cyc_q [$];

    task automatic do_req(input bit we, input int addr, input logic [7:0] d);
        host_req   = 1'b1;
        host_we    = we;
        host_addr  = 23'(addr);
        host_wdata = d;
        forever begin
            @(negedge clk);
            if (host_ack) break;
        end
        host_req = 1'b0;
        addr_q.push_back(addr);
        we_q.push_back(we);
        dat_q.push_back(d);
        if (we) exp_mem[addr] = d;
        else    sb_q.push_back(exp_mem.exists(addr) ? exp_mem[addr] : 8'h00);
    endtask

    function automatic int mk(input int b, input int r, input int c);
        return (b << 21) | (r << 9) | c;
    endfunction

    // ---------------- monitor ----------------
    int cyc = 0, mrs_cyc = -1000, last_act = -1000, last_pre = -1000, last_ref = -1000;
    int init_idx = 0, post_refs = 0, act_bank = 0;
    bit act_seen = 0, pre_seen = 0, ref_pending_chk = 0, prev_ack = 0;
    logic [3:0] c;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            cyc++;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (host_ack) begin
                chk(init_idx == 4 && (cyc - mrs_cyc) >= 2, "R4 ack after init", cyc - mrs_cyc, 2);
                chk(!prev_ack, "R11 ack pulse", int'(prev_ack), 0);
            end
            prev_ack = host_ack;
            if (sd_dq_oe) chk(c == 4'b0100, "R8 oe only with WRITE", int'(c), 4'b0100);
            if (!sd_cs_n && c != 4'b0111) begin
                if (ref_pending_chk) begin
                    chk((cyc - last_ref) >= 9, "R12 refresh recovery", cyc - last_ref, 9);
                    ref_pending_chk = 0;
                end
                if (init_idx < 4) begin
                    case (init_idx)
                        0: begin
                            chk(c == 4'b0010 && sd_a[10], "R2 first PRECHARGE all", int'(c), 4'b0010);
                            chk(cyc >= PWR, "R2 power-up wait", cyc, PWR);
                        end
                        1, 2: chk(c == 4'b0001, "R2 init AUTO REFRESH", int'(c), 4'b0001);
                        default: begin
                            chk(c == 4'b0000, "R2 MODE REGISTER SET", int'(c), 0);
                            chk(sd_a == 12'h230 && sd_ba == 2'd0, "R2 mode value", int'(sd_a), 12'h230);
                            chk(sd_dqm == 1'b1, "R1 dqm high through init", int'(sd_dqm), 1);
                            mrs_cyc = cyc;
                        end
                    endcase
                    init_idx++;
                end else begin
                    if (c == 4'b0011 || c == 4'b0001) begin
                        if (pre_seen) chk((cyc - last_pre) >= 3, "R7 tRP", cyc - last_pre, 3);
                    end
                    if (c == 4'b0011) begin
                        if (act_seen) chk((cyc - last_act) >= 9, "R7 tRC", cyc - last_act, 9);
                        if (addr_q.size() > 0) begin
                            chk(int'(sd_ba) == (addr_q[0] >> 21), "R3 R5 ACT bank", int'(sd_ba), addr_q[0] >> 21);
                            chk(int'(sd_a) == ((addr_q[0] >> 9) & 12'hFFF), "R3 R5 ACT row",
                                int'(sd_a), (addr_q[0] >> 9) & 12'hFFF);
                        end else chk(0, "R5 ACT without request", 0, 1);
                        act_bank = int'(sd_ba);
                        last_act = cyc; act_seen = 1;
                    end
                    if (c == 4'b0100 || c == 4'b0101) begin
                        chk((cyc - last_act) == 3, "R6 tRCD exact", cyc - last_act, 3);
                        chk(sd_dqm == 1'b0, "R1 dqm low on access", int'(sd_dqm), 0);
                        if (addr_q.size() > 0) begin
                            chk(int'(sd_ba) == act_bank, "R5 column bank", int'(sd_ba), act_bank);
                            chk(int'(sd_a[8:0]) == (addr_q[0] & 9'h1FF), "R3 R5 column",
                                int'(sd_a[8:0]), addr_q[0] & 9'h1FF);
                            chk(sd_a[11:9] == 3'b000, "R5 A9-A11 low", int'(sd_a[11:9]), 0);
                            chk((c == 4'b0100) == we_q[0], "R5 direction", int'(c), we_q[0] ? 4 : 5);
                            if (c == 4'b0100)
                                chk(sd_dq_oe && sd_dq_out == dat_q[0], "R8 write data",
                                    int'(sd_dq_out), int'(dat_q[0]));
                            void'(addr_q.pop_front()); void'(we_q.pop_front()); void'(dat_q.pop_front());
                        end
                        if (c == 4'b0101) rd_cyc_q.push_back(cyc);
                    end
                    if (c == 4'b0010) begin
                        chk(!sd_a[10] && int'(sd_ba) == act_bank, "R6 bank precharge",
                            int'({sd_a[10], sd_ba}), act_bank);
                        chk((cyc - last_act) >= 6, "R6 tRAS", cyc - last_act, 6);
                    end
                    if (c == 4'b0001) begin
                        chk((cyc - last_ref) <= REFI + 16, "R10 refresh interval", cyc - last_ref, REFI + 16);
                        post_refs++;
                    end
                end
                if (c == 4'b0010) begin last_pre = cyc; pre_seen = 1; end
                if (c == 4'b0001) begin last_ref = cyc; ref_pending_chk = 1; end
            end
            if (host_rvalid) begin
                if (rd_cyc_q.size() > 0)
                    chk((cyc - rd_cyc_q.pop_front()) == CL + 1, "R9 read latency",
                        cyc - (rd_cyc_q.size() >= 0 ? cyc - CL - 1 : 0), CL + 1);
                if (sb_q.size() > 0) begin
                    logic [7:0] e;
                    e = sb_q.pop_front();
                    chk(host_rdata == e, "R9 read data", int'(host_rdata), int'(e));
                end else chk(0, "R9 unexpected rvalid", 1, 0);
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(sd_cke == 1'b0, "R1 reset cke", int'(sd_cke), 0);
        chk(sd_cs_n == 1'b1, "R1 reset cs_n", int'(sd_cs_n), 1);
        chk(sd_dqm == 1'b1, "R1 reset dqm", int'(sd_dqm), 1);
        chk(!host_ack && !host_rvalid, "R1 reset host outputs", int'({host_ack, host_rvalid}), 0);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // request held through initialisation (R4)
        do_req(1, mk(0, 0, 0), 8'hA5);
        do_req(1, mk(3, 12'hFFF, 9'h1FF), 8'h3C);
        do_req(1, mk(1, 12'h5A5, 9'h0AA), 8'h81);
        do_req(1, mk(2, 12'h123, 9'h100), 8'h7E);
        do_req(0, mk(0, 0, 0), 8'h00);
        do_req(0, mk(3, 12'hFFF, 9'h1FF), 8'h00);
        do_req(0, mk(1, 12'h5A5, 9'h0AA), 8'h00);
        do_req(0, mk(2, 12'h123, 9'h100), 8'h00);
        do_req(1, mk(3, 12'hFFF, 9'h1FF), 8'hC3);
        do_req(0, mk(3, 12'hFFF, 9'h1FF), 8'h00);
        // back-to-back traffic across several refresh periods (R10)
        for (int i = 0; i < 350; i++) begin
            do_req(1, mk(i % 4, (i * 37) % 4096, (i * 11) % 512), 8'(i * 7 + 3));
            do_req(0, mk(i % 4, (i * 37) % 4096, (i * 11) % 512), 8'h00);
        end
        repeat (2200) @(negedge clk);
        chk(sb_q.size() == 0, "R9 all reads returned", sb_q.size(), 0);
        chk(post_refs >= 4, "R10 refresh count", post_refs, 4);
        finish_test();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end
endmodule